// File: doc/BRIEF.md
# LCD Frame Timing Generator

The block turns a free-running input clock into the frame and multiplex-phase timing of a low-multiplex LCD segment driver. A frame lasts 2880 input clocks in normal mode and 480 input clocks in power-saving mode. Each frame is split evenly into one to four multiplex phases, one phase for each backplane. At the start of every phase the block asks display RAM for the column of the next phase and captures the returned word in a staging register. At the phase boundary that word moves into the display latch, which drives the segment outputs. One column is therefore fetched while the previous column is still being shown.

Several drivers can share one frame rhythm. A device strapped as master emits a one-clock pulse at the start of every frame. A device strapped as slave ignores its own frame ends for that output and restarts its frame whenever the shared pulse arrives. The mode bit and the backplane count come from a command register elsewhere in the design. They are taken over only at a frame start, so no frame is ever cut short by a mode change.

A small handshake flags the bus side when a new display byte is offered before the previous byte has been stored. The flag holds the sender off, so no byte is lost.

Top module: `lcd_frame_timer`

## Requirements
- R1: A synchronous active-high reset clears the divider, the phase counter, the staging register, the display latch and the pending-byte flag. It also selects normal mode with a single phase. In the first cycle after reset, seg_o, phase_o, sync_o and busy_o are all 0, and seg_o stays 0 for the whole first frame.
- R2: In normal mode (save_mode_i = 0 taken over at a frame start), a master device pulses sync_o every 2880 clocks. With the default parameters, the first pulse after reset comes 2880 clocks after reset is released.
- R3: In power-saving mode (save_mode_i = 1 taken over at a frame start), a master device pulses sync_o every 480 clocks.
- R4: The value n on bp_sel_i gives n+1 phases per frame. Each phase lasts frame_length/(n+1) clocks. phase_o counts 0, 1, … n within each frame and returns to 0 at the frame start.
- R5: RAM is read with one clock of latency. ram_rd_o is high in the first clock of every phase, and ram_addr_o then holds the index of the following phase (0 after the last phase). In every phase p of a steady frame, seg_o equals the RAM word at address p.
- R6: seg_o changes only in the first clock of a phase. Within a phase it holds its value.
- R7: Changes on save_mode_i and bp_sel_i have no effect on the frame in progress. They govern the frame that starts next.
- R8: With master_i = 1, sync_o is a one-clock pulse in the first clock of every frame, with no pulse inside a frame. No pulse is produced for the frame that begins at reset.
- R9: With master_i = 0, sync_o stays 0. A high sync_i sampled at a clock edge restarts the frame: in the next clock phase_o is 0, the new phase 0 lasts a full phase length, and the mode inputs are taken over at that edge.
- R10: A byte offered on byte_valid_i while no byte is pending is accepted, and the byte becomes pending from the next clock. While a byte is pending, busy_o equals byte_valid_i. A store_done_i pulse clears the pending state at that edge, and busy_o is never high without byte_valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that the frame timing is divided from |
| rst | input | 1 | Synchronous active-high reset |
| save_mode_i | input | 1 | 1 selects the 480-clock frame, 0 the 2880-clock frame |
| bp_sel_i | input | 2 | Number of phases minus one |
| master_i | input | 1 | 1 makes the device drive sync_o, 0 makes it follow sync_i |
| sync_i | input | 1 | Frame restart pulse from the master (slave mode) |
| sync_o | output | 1 | Frame start pulse (master mode) |
| ram_rd_o | output | 1 | Display RAM read strobe |
| ram_addr_o | output | 2 | Column index to read |
| ram_data_i | input | SEG_W | RAM word, valid one clock after the strobe |
| seg_o | output | SEG_W | Display latch contents driving the segments |
| phase_o | output | 2 | Current multiplex phase |
| byte_valid_i | input | 1 | A display byte is offered |
| store_done_i | input | 1 | The pending byte has been stored |
| busy_o | output | 1 | Offered byte cannot be accepted yet |

## Verification
The hardest state to reach from the ports is a mode change that lands inside a running frame with several phases. The old length and the old phase count must then hold until that frame ends, and the staging register must still deliver column 0 for the first phase of the new frame. The bench gets there by changing the mode inputs in the first clock of each frame, using random mode and phase-count pairs drawn with a fixed seed. It then measures that frame against the old settings and the following frame against the new ones. The slave restart is forced in the middle of a phase, and the bench then returns to master mode to confirm that the column order recovers.

// File: rtl/lcd_ft_pkg.sv
package lcd_ft_pkg;

  // Frame length in input clocks for the selected mode.
  function automatic int unsigned frame_total(logic save, int unsigned norm_div,
                                              int unsigned save_div);
    return save ? save_div : norm_div;
  endfunction

  // Length of one phase: the frame split evenly over bp+1 phases.
  function automatic int unsigned phase_len(int unsigned total, logic [1:0] bp);
    case (bp)
      2'd0:    return total;
      2'd1:    return total / 2;
      2'd2:    return total / 3;
      default: return total / 4;
    endcase
  endfunction

endpackage

// File: rtl/lcd_ft_divider.sv
module lcd_ft_divider #(
  parameter int unsigned NORM_DIV = 2880,
  parameter int unsigned SAVE_DIV = 480,
  localparam int unsigned CNT_W = $clog2(NORM_DIV + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       save_i,
  input  logic [1:0] bp_i,
  input  logic       master_i,
  input  logic       sync_i,
  output logic [1:0] phase_o,
  output logic [1:0] bp_cur_o,
  output logic [1:0] next_phase_o,
  output logic       div_zero_o,
  output logic       phase_adv_o,
  output logic       sync_o
);
  import lcd_ft_pkg::*;

  logic [CNT_W-1:0] div_q;
  logic [1:0]       phase_q;
  logic [1:0]       bp_q;
  logic             save_q;
  logic             sync_q;
  logic             restart_w;
  logic             phase_end_w;
  logic             last_phase_w;
  logic             frame_end_w;
  int unsigned      len_w;

  assign len_w        = phase_len(frame_total(save_q, NORM_DIV, SAVE_DIV), bp_q);
  assign restart_w    = ~master_i & sync_i;
  assign phase_end_w  = (32'(div_q) == len_w - 1);
  assign last_phase_w = (phase_q == bp_q);
  assign frame_end_w  = phase_end_w & last_phase_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      phase_q <= '0;
      bp_q    <= '0;
      save_q  <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      sync_q <= master_i & frame_end_w;
      if (restart_w) begin
        div_q   <= '0;
        phase_q <= '0;
        bp_q    <= bp_i;
        save_q  <= save_i;
      end else if (phase_end_w) begin
        div_q <= '0;
        if (last_phase_w) begin
          phase_q <= '0;
          bp_q    <= bp_i;
          save_q  <= save_i;
        end else begin
          phase_q <= phase_q + 2'd1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign phase_o      = phase_q;
  assign bp_cur_o     = bp_q;
  assign next_phase_o = last_phase_w ? 2'd0 : phase_q + 2'd1;
  assign div_zero_o   = (div_q == '0);
  assign phase_adv_o  = phase_end_w & ~restart_w;
  assign sync_o       = sync_q;
endmodule

// File: rtl/lcd_ft_column.sv
module lcd_ft_column #(
  parameter int unsigned SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_i,
  input  logic [1:0]       next_phase_i,
  input  logic             adv_i,
  input  logic [SEG_W-1:0] ram_data_i,
  output logic             ram_rd_o,
  output logic [1:0]       ram_addr_o,
  output logic [SEG_W-1:0] seg_o
);
  logic             rd_q;
  logic [SEG_W-1:0] stage_q;
  logic [SEG_W-1:0] latch_q;

  assign ram_rd_o   = fetch_i & ~rst;
  assign ram_addr_o = next_phase_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= 1'b0;
      stage_q <= '0;
      latch_q <= '0;
    end else begin
      rd_q <= ram_rd_o;
      if (rd_q) stage_q <= ram_data_i;
      if (adv_i) latch_q <= stage_q;
    end
  end

  assign seg_o = latch_q;
endmodule

// File: rtl/lcd_ft_busy.sv
module lcd_ft_busy (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  input  logic done_i,
  output logic busy_o
);
  logic pend_q;
  logic accept_w;

  assign accept_w = valid_i & ~pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= accept_w | (pend_q & ~done_i);
  end

  assign busy_o = valid_i & pend_q;
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
  parameter int unsigned SEG_W    = 8,
  parameter int unsigned NORM_DIV = 2880,
  parameter int unsigned SAVE_DIV = 480
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             save_mode_i,
  input  logic [1:0]       bp_sel_i,
  input  logic             master_i,
  input  logic             sync_i,
  output logic             sync_o,
  output logic             ram_rd_o,
  output logic [1:0]       ram_addr_o,
  input  logic [SEG_W-1:0] ram_data_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [1:0]       phase_o,
  input  logic             byte_valid_i,
  input  logic             store_done_i,
  output logic             busy_o
);
  logic [1:0] bp_cur_w;
  logic [1:0] next_phase_w;
  logic       div_zero_w;
  logic       phase_adv_w;

  lcd_ft_divider #(.NORM_DIV(NORM_DIV), .SAVE_DIV(SAVE_DIV)) u_div (
    .clk(clk), .rst(rst), .save_i(save_mode_i), .bp_i(bp_sel_i),
    .master_i(master_i), .sync_i(sync_i), .phase_o(phase_o),
    .bp_cur_o(bp_cur_w), .next_phase_o(next_phase_w),
    .div_zero_o(div_zero_w), .phase_adv_o(phase_adv_w), .sync_o(sync_o)
  );

  lcd_ft_column #(.SEG_W(SEG_W)) u_col (
    .clk(clk), .rst(rst), .fetch_i(div_zero_w), .next_phase_i(next_phase_w),
    .adv_i(phase_adv_w), .ram_data_i(ram_data_i), .ram_rd_o(ram_rd_o),
    .ram_addr_o(ram_addr_o), .seg_o(seg_o)
  );

  lcd_ft_busy u_busy (
    .clk(clk), .rst(rst), .valid_i(byte_valid_i), .done_i(store_done_i),
    .busy_o(busy_o)
  );
endmodule

// File: rtl/lcd_frame_timer_chk.sv
module lcd_frame_timer_chk #(
  parameter int unsigned SEG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             master_i,
  input logic             sync_i,
  input logic             sync_o,
  input logic             ram_rd_o,
  input logic [SEG_W-1:0] seg_o,
  input logic [1:0]       phase_o,
  input logic [1:0]       bp_cur,
  input logic             phase_adv,
  input logic             byte_valid_i,
  input logic             busy_o
);
  p_sync_one_shot_r8: assert property (@(posedge clk) disable iff (rst)
    sync_o |=> !sync_o);

  p_slave_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(master_i) |-> !sync_o);

  p_restart_phase0_r9: assert property (@(posedge clk) disable iff (rst)
    (!master_i && sync_i) |=> (phase_o == 2'd0));

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(phase_adv) |-> $stable(seg_o));

  p_phase_bound_r4: assert property (@(posedge clk) disable iff (rst)
    phase_o <= bp_cur);

  p_fetch_at_start_r5: assert property (@(posedge clk) disable iff (rst)
    phase_adv |=> ram_rd_o);

  p_busy_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> byte_valid_i);
endmodule

bind lcd_frame_timer lcd_frame_timer_chk #(.SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst(rst), .master_i(master_i), .sync_i(sync_i), .sync_o(sync_o),
  .ram_rd_o(ram_rd_o), .seg_o(seg_o), .phase_o(phase_o), .bp_cur(bp_cur_w),
  .phase_adv(phase_adv_w), .byte_valid_i(byte_valid_i), .busy_o(busy_o)
);

// File: tb/lcd_frame_timer_bench.sv
module lcd_frame_timer_bench;
  localparam int unsigned SEG_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             save_mode_i = 1'b0;
  logic [1:0]       bp_sel_i = 2'd0;
  logic             master_i = 1'b1;
  logic             sync_i = 1'b0;
  logic             sync_o;
  logic             ram_rd_o;
  logic [1:0]       ram_addr_o;
  logic [SEG_W-1:0] ram_data_i = '0;
  logic [SEG_W-1:0] seg_o;
  logic [1:0]       phase_o;
  logic             byte_valid_i = 1'b0;
  logic             store_done_i = 1'b0;
  logic             busy_o;

  logic [SEG_W-1:0] mem [4];
  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic        cur_save;
  logic [1:0]  cur_bp;

  always #4 clk = ~clk;

  lcd_frame_timer #(.SEG_W(SEG_W)) u_lcd_frame_timer (
    .clk(clk), .rst(rst), .save_mode_i(save_mode_i), .bp_sel_i(bp_sel_i),
    .master_i(master_i), .sync_i(sync_i), .sync_o(sync_o), .ram_rd_o(ram_rd_o),
    .ram_addr_o(ram_addr_o), .ram_data_i(ram_data_i), .seg_o(seg_o),
    .phase_o(phase_o), .byte_valid_i(byte_valid_i), .store_done_i(store_done_i),
    .busy_o(busy_o)
  );

  // RAM model with one clock of read latency.
  always @(posedge clk) if (ram_rd_o) ram_data_i <= mem[ram_addr_o];

  function automatic int unsigned exp_frame(logic sv);
    return sv ? 480 : 2880;
  endfunction

  function automatic int unsigned exp_phase(logic sv, logic [1:0] bp);
    return exp_frame(sv) / (int'(bp) + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  // Entered at the negedge of the first clock of a frame (sync_o high).
  task automatic measure_frame(input logic sv, input logic [1:0] bp);
    int unsigned total = exp_frame(sv);
    int unsigned len = exp_phase(sv, bp);
    int bad_ph = 0, bad_seg = 0, bad_sync = 0;
    for (int unsigned c = 0; c < total; c++) begin
      if (32'(phase_o) != c / len) bad_ph++;
      if (seg_o != mem[c / len]) bad_seg++;
      if (c > 0 && sync_o) bad_sync++;
      @(negedge clk);
    end
    chk(bad_ph == 0, "R4 phase sequence", bad_ph, 0);
    chk(bad_seg == 0, "R5 R6 column per phase", bad_seg, 0);
    chk(bad_sync == 0, "R8 no pulse inside frame", bad_sync, 0);
    chk(sync_o == 1'b1, sv ? "R3 saving frame length" : "R2 normal frame length",
        int'(sync_o), 1);
  endtask

  initial begin
    void'($urandom(32'd2417));
    for (int i = 0; i < 4; i++) mem[i] = {2'(i), 6'($urandom)};
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(seg_o == '0, "R1 seg after reset", int'(seg_o), 0);
    chk(phase_o == 2'd0, "R1 phase after reset", int'(phase_o), 0);
    chk(sync_o == 1'b0, "R1 sync after reset", int'(sync_o), 0);
    chk(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
    // First frame: normal, single phase; inputs changed mid-frame (R7).
    save_mode_i = 1'b1;
    bp_sel_i = 2'd3;
    begin
      int early = 0, seg_nz = 0;
      for (int k = 1; k <= 2880; k++) begin
        if (seg_o != '0) seg_nz++;
        @(negedge clk);
        if (k < 2880 && sync_o) early++;
        if (k < 2880 && phase_o != 2'd0) early++;
      end
      chk(early == 0, "R7 R1 first frame single phase normal", early, 0);
      chk(seg_nz == 0, "R1 seg zero in first frame", seg_nz, 0);
      chk(sync_o == 1'b1, "R2 first pulse 2880 after reset", int'(sync_o), 1);
    end
    cur_save = 1'b1; cur_bp = 2'd3;
    measure_frame(cur_save, cur_bp);
    // Directed: change to normal, 3 phases at frame start (R7).
    save_mode_i = 1'b0; bp_sel_i = 2'd2;
    measure_frame(cur_save, cur_bp);
    cur_save = 1'b0; cur_bp = 2'd2;
    // Random mode pairs.
    for (int it = 0; it < 7; it++) begin
      logic ns = 1'($urandom);
      logic [1:0] nb = 2'($urandom);
      save_mode_i = ns; bp_sel_i = nb;
      measure_frame(cur_save, cur_bp);   // R7 old settings still govern
      cur_save = ns; cur_bp = nb;
    end
    measure_frame(cur_save, cur_bp);
    // Slave restart in the middle of a phase (R9).
    master_i = 1'b0;
    begin
      int bad = 0;
      repeat (300) begin
        @(negedge clk);
        if (sync_o) bad++;
      end
      save_mode_i = 1'b1; bp_sel_i = 2'd3;
      sync_i = 1'b1;
      @(negedge clk);
      sync_i = 1'b0;
      chk(phase_o == 2'd0, "R9 restart to phase 0", int'(phase_o), 0);
      for (int c = 1; c <= 120; c++) begin
        @(negedge clk);
        if (c < 120 && phase_o != 2'd0) bad++;
      end
      chk(phase_o == 2'd1, "R9 full phase after restart, new mode", int'(phase_o), 1);
      repeat (600) begin
        @(negedge clk);
        if (sync_o) bad++;
      end
      chk(bad == 0, "R9 slave keeps sync_o low", bad, 0);
    end
    master_i = 1'b1;
    begin
      int got = 0;
      for (int i = 0; i < 600; i++) begin
        @(negedge clk);
        if (sync_o) begin got = 1; break; end
      end
      chk(got == 1, "R8 pulse resumes in master", got, 1);
    end
    cur_save = 1'b1; cur_bp = 2'd3;
    measure_frame(cur_save, cur_bp);
    // Busy handshake (R10).
    byte_valid_i = 1'b1;
    #1 chk(busy_o == 1'b0, "R10 first byte accepted", int'(busy_o), 0);
    @(negedge clk);
    chk(busy_o == 1'b1, "R10 second byte held off", int'(busy_o), 1);
    @(negedge clk);
    chk(busy_o == 1'b1, "R10 still held off", int'(busy_o), 1);
    store_done_i = 1'b1;
    @(negedge clk);
    store_done_i = 1'b0;
    #1 chk(busy_o == 1'b0, "R10 accepted after store", int'(busy_o), 0);
    @(negedge clk);
    chk(busy_o == 1'b1, "R10 pending again", int'(busy_o), 1);
    byte_valid_i = 1'b0;
    #1 chk(busy_o == 1'b0, "R10 no busy without valid", int'(busy_o), 0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule